// File: doc/BRIEF.md
# Sliding Window Packet Accumulator

This block turns a stream of per-packet tone verdicts into a steady, active-low detect output. Each time an upstream measurement stage finishes one packet, it pulses a strobe and gives a good/bad flag. The block keeps the most recent verdicts in a shift history. It counts how many good and how many bad verdicts fall inside a window whose length depends on the selected tone system. The output asserts when the good count reaches a threshold. It releases when the bad count reaches the same threshold. Between those two points it holds, so short fades in a real tone and short bursts of stray energy leave the output where it was.

A system select input picks between two window sizes. The 12 kHz system uses 18 packets with a threshold of 15. The 16 kHz system uses 24 packets with a threshold of 20. In both systems this works out to a 48 ms window with 40 ms of cumulative agreement required. Changing the select throws away the history and reports no tone.

Top module: `pkt_window_debounce`

## Requirements
- R1: After reset `det_n` is 1 and every history entry counts as bad. With `sys_12k`=1, the first 14 good packets leave `det_n` at 1.
- R2: With `sys_12k`=1, the window is the newest 18 packets. `det_n` goes to 0 once at least 15 of them are good, so 15 consecutive good packets after an all-bad history assert it on the 15th.
- R3: With `sys_12k`=0, the window is the newest 24 packets and the threshold is 20, so 20 consecutive good packets from an all-bad history assert on the 20th.
- R4: While `det_n` is 0, it returns to 1 once the number of bad packets in the window reaches the threshold for the mode.
- R5: When the count of the opposite kind is below the threshold, `det_n` holds its value, so isolated dropouts or bursts do not change it.
- R6: `det_n` changes only on the second rising edge after the edge that accepts a strobe, or on the edge after a mode change.
- R7: A change of `sys_12k` clears the history to all bad and drives `det_n` to 1 on the next edge. A strobe presented in the same cycle as the change is discarded.
- R8: Packets older than the window for the current mode carry no weight in either count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_12k | input | 1 | System select: 1 = 12 kHz (18-packet window), 0 = 16 kHz (24-packet window) |
| pkt_valid | input | 1 | One-cycle strobe: a packet verdict is present |
| pkt_good | input | 1 | Verdict for the strobed packet: 1 = good tone |
| det_n | output | 1 | Active-low detect: 0 = tone present, 1 = no tone |

## Verification
The assertions assume that `pkt_valid` is a single-cycle pulse with at least one idle cycle between strobes. They also assume that `sys_12k` is held steady except at deliberate switch points. The bench drives every strobe for exactly one cycle and leaves an idle cycle after it. It changes the system select only between packets, apart from one deliberate switch that lands on a strobe to show that the strobe is discarded. Under those conditions, every output change can be traced to the single evaluation that follows an accepted packet, or to a clear.

// File: rtl/pkt_win_pkg.sv
// Shared definitions for the sliding window packet accumulator.
package pkt_win_pkg;
    // System select encoding as seen on the sys_12k pin.
    typedef enum logic {
        SYS_16K = 1'b0,
        SYS_12K = 1'b1
    } sys_mode_e;

    // Output polarity: the detect line is active low.
    localparam logic DET_ON  = 1'b0;
    localparam logic DET_OFF = 1'b1;
endpackage

// File: rtl/pkt_history.sv
// Packet verdict history.
// Holds the newest DEPTH verdicts, with bit 0 the newest. A shift pushes
// one verdict in. A clear, or reset, fills every entry with "bad" (0).
// Assumes shift_en and clear are never both acted on; clear wins.
module pkt_history #(
    parameter int DEPTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             clear,
    input  logic             bit_in,
    output logic [DEPTH-1:0] hist
);
    // Shift register update: clear has priority over a new verdict.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[DEPTH-2:0], bit_in};
        end
    end

    // The history must not change without a shift or a clear.
    assert_hist_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!shift_en) && $past(!clear)) |-> $stable(hist));
endmodule

// File: rtl/pkt_window_count.sv
// Windowed population count.
// Counts good and bad entries among the newest WIN entries of the history.
// WIN and the threshold come from the system select. Entries older than the
// window are masked out. Purely combinational.
module pkt_window_count #(
    parameter int DEPTH   = 24,
    parameter int WIN_12K = 18,
    parameter int WIN_16K = 24,
    parameter int THR_12K = 15,
    parameter int THR_16K = 20,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] hist,
    input  logic             sys_12k,
    output logic [CNT_W-1:0] good_cnt,
    output logic [CNT_W-1:0] bad_cnt,
    output logic [CNT_W-1:0] thr
);
    localparam logic [CNT_W-1:0] W12 = CNT_W'(WIN_12K);
    localparam logic [CNT_W-1:0] W16 = CNT_W'(WIN_16K);
    localparam logic [CNT_W-1:0] T12 = CNT_W'(THR_12K);
    localparam logic [CNT_W-1:0] T16 = CNT_W'(THR_16K);

    logic [DEPTH-1:0] mask12, mask16, masked;
    logic [CNT_W-1:0] win_len;

    // One mask bit per history position for each window length.
    for (genvar i = 0; i < DEPTH; i++) begin : g_mask
        assign mask12[i] = (i < WIN_12K);
        assign mask16[i] = (i < WIN_16K);
    end

    // Select the window length and threshold for the active system.
    always_comb begin
        win_len = sys_12k ? W12 : W16;
        thr     = sys_12k ? T12 : T16;
        masked  = hist & (sys_12k ? mask12 : mask16);
    end

    // Population count over the masked window, plus its complement.
    always_comb begin
        good_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            good_cnt = good_cnt + CNT_W'(masked[i]);
        end
        bad_cnt = win_len - good_cnt;
    end

    // The good count never exceeds the window (guards R8 masking).
    assert_cnt_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        good_cnt <= win_len);
endmodule

// File: rtl/pkt_hyst_out.sv
// Hysteresis output stage.
// On each evaluation pulse, the detect line asserts (low) when the good count
// reaches the threshold. It releases (high) when the bad count reaches it.
// Otherwise it holds. A clear forces no-tone. Assumes at most one
// evaluation per accepted packet.
module pkt_hyst_out #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic             clear,
    input  logic [CNT_W-1:0] good_cnt,
    input  logic [CNT_W-1:0] bad_cnt,
    input  logic [CNT_W-1:0] thr,
    output logic             det_n
);
    import pkt_win_pkg::*;

    // Output state: flip only when the opposite kind reaches the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            det_n <= DET_OFF;
        end else if (eval) begin
            if (det_n == DET_OFF && good_cnt >= thr) begin
                det_n <= DET_ON;
            end else if (det_n == DET_ON && bad_cnt >= thr) begin
                det_n <= DET_OFF;
            end
        end
    end

    assert_assert_needs_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det_n) |-> $past(good_cnt >= thr));
    assert_release_needs_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_n) |-> $past((bad_cnt >= thr) || clear));
endmodule

// File: rtl/pkt_window_debounce.sv
// Sliding window packet accumulator (top).
// Accepts one verdict per packet strobe and keeps a history. It drives an
// active-low detect line with count-based hysteresis over a window chosen by
// sys_12k. A change of system clears the history and the output; a strobe in
// that same cycle is dropped. Assumes pkt_valid is a single-cycle pulse.
module pkt_window_debounce #(
    parameter int DEPTH   = 24,
    parameter int WIN_12K = 18,
    parameter int WIN_16K = 24,
    parameter int THR_12K = 15,
    parameter int THR_16K = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_12k,
    input  logic pkt_valid,
    input  logic pkt_good,
    output logic det_n
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             mode_q;
    logic             mode_chg;
    logic             accept;
    logic             eval_q;
    logic [DEPTH-1:0] hist;
    logic [CNT_W-1:0] good_cnt, bad_cnt, thr;

    assign mode_chg = (sys_12k != mode_q);
    assign accept   = pkt_valid && !mode_chg;

    // Track the system select so a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= sys_12k;
        else        mode_q <= sys_12k;
    end

    // Evaluate one cycle after a packet has entered the history.
    always_ff @(posedge clk) begin
        if (!rst_n) eval_q <= 1'b0;
        else        eval_q <= accept;
    end

    pkt_history #(.DEPTH(DEPTH)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .clear    (mode_chg),
        .bit_in   (pkt_good),
        .hist     (hist)
    );

    pkt_window_count #(
        .DEPTH   (DEPTH),
        .WIN_12K (WIN_12K),
        .WIN_16K (WIN_16K),
        .THR_12K (THR_12K),
        .THR_16K (THR_16K),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hist     (hist),
        .sys_12k  (mode_q),
        .good_cnt (good_cnt),
        .bad_cnt  (bad_cnt),
        .thr      (thr)
    );

    pkt_hyst_out #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval     (eval_q),
        .clear    (mode_chg),
        .good_cnt (good_cnt),
        .bad_cnt  (bad_cnt),
        .thr      (thr),
        .det_n    (det_n)
    );

    assert_change_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (det_n != $past(det_n)) |-> $past(eval_q || mode_chg));
    assert_mode_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (det_n && hist == '0));
endmodule

// File: tb/tb_pkt_window_debounce.sv
module tb_pkt_window_debounce;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_12k = 1'b1;
    logic pkt_valid = 1'b0;
    logic pkt_good = 1'b0;
    logic det_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    bit hist_m[DEPTH];
    bit det_m = 1'b1;
    bit mode_m = 1'b1;
    logic exp_q[$];
    string tag_q[$];
    event sent_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_window_debounce dut (
        .clk(clk), .rst_n(rst_n), .sys_12k(sys_12k),
        .pkt_valid(pkt_valid), .pkt_good(pkt_good), .det_n(det_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: det_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) hist_m[i] = 0;
        det_m = 1'b1;
    endtask

    // Push one verdict into the model and work out the expected output.
    task automatic model_push(input bit g);
        int win, thr, good;
        for (int i = DEPTH-1; i > 0; i--) hist_m[i] = hist_m[i-1];
        hist_m[0] = g;
        win = mode_m ? 18 : 24;
        thr = mode_m ? 15 : 20;
        good = 0;
        for (int i = 0; i < win; i++) good += hist_m[i];
        if (det_m && good >= thr) det_m = 1'b0;
        else if (!det_m && (win - good) >= thr) det_m = 1'b1;
    endtask

    // Driver: strobe one packet and queue the expected result.
    task automatic send(input bit g, input string tag);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_good = g;
        model_push(g);
        exp_q.push_back(det_m);
        tag_q.push_back(tag);
        @(negedge clk);
        pkt_valid = 1'b0;
        -> sent_ev;
        @(negedge clk);
    endtask

    // Monitor: two edges after acceptance, compare with the queue.
    initial begin
        forever begin
            @(sent_ev);
            @(negedge clk);
            if (exp_q.size() > 0) check(det_n, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        int n;
        bit [15:0] lfsr;
        model_clear();
        repeat (3) @(negedge clk);
        check(det_n, 1'b1, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(det_n, 1'b1, "R1 after reset");

        // R1/R2: 14 goods stay high, 15th asserts.
        for (int i = 0; i < 14; i++) send(1, "R1 below threshold");
        send(1, "R2 15th good asserts");
        // R5: isolated dropouts hold the output.
        send(0, "R5 dropout holds");
        send(1, "R5 hold");
        send(0, "R5 dropout holds");
        // R4: run of bad packets releases on threshold.
        for (int i = 0; i < 16; i++) send(0, "R4 release");
        // R5: short good burst does not assert.
        for (int i = 0; i < 5; i++) send(1, "R5 burst ignored");

        // R7: switch to 16 kHz with a strobe in the same cycle; it is dropped.
        for (int i = 0; i < 18; i++) send(1, "R2 refill");
        @(negedge clk);
        sys_12k = 1'b0;
        pkt_valid = 1'b1;
        pkt_good = 1'b1;
        mode_m = 1'b0;
        model_clear();
        @(negedge clk);
        pkt_valid = 1'b0;
        check(det_n, 1'b1, "R7 mode change clears");
        @(negedge clk);
        // R3: 19 goods stay high, 20th asserts.
        for (int i = 0; i < 19; i++) send(1, "R3 below threshold");
        send(1, "R3 20th good asserts");
        for (int i = 0; i < 20; i++) send(0, "R4 release 16k");

        // R8: back to 12 kHz, mixed pattern against the windowed model.
        @(negedge clk);
        sys_12k = 1'b1;
        mode_m = 1'b1;
        model_clear();
        @(negedge clk);
        check(det_n, 1'b1, "R7 clear to 12k");
        lfsr = 16'hACE1;
        n = 0;
        for (int i = 0; i < 150; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            // Bias runs: mostly good in one phase, mostly bad in the next.
            send(((i / 30) % 2 == 0) ? (lfsr[2:0] != 0) : (lfsr[2:0] == 0), "R8 windowed");
            n++;
        end
        repeat (3) @(negedge clk);
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: timeout actual=%0d expected=finish", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule